// File: doc/BRIEF.md
# Phase-Alignable Divide-by-Three Clock Generator

This block derives a processor clock at one third of a fast input clock, a peripheral clock at half the processor clock rate, and a retimed active-high reset from an active-low reset request. A strap input picks one of two source clocks, an oscillator clock or an external frequency input, to drive the divider. The raw oscillator clock is also passed through on its own output, so it stays usable as a separate source.

Both source clocks are treated as digital levels. They are sampled by a faster system clock, and each rising edge of the selected source counts as one input-clock event, called a tick below. A clear input can hold the divider and the peripheral clock so that several generators start in phase. By default the clear passes through a two-flop synchronizer that is clocked by source ticks. A parameter can remove that synchronizer.

Top module: `phase_div3_clkgen`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, the next state is `main_clk`=0, `periph_clk`=0 and `reset_out`=1. The divider is parked in its last state, and both source-edge detectors read their previous level as 0.
- R2: With the clear inactive, `main_clk` is high for exactly one tick out of every three. It becomes high on the tick that follows the parked state. It changes only on ticks.
- R3: `src_sel`=0 selects `xtal_in` and `src_sel`=1 selects `ext_in`. Only a rising edge of the selected source is a tick. Activity on the other source leaves every divided output unchanged.
- R4: `periph_clk` toggles on each tick where `main_clk` falls from 1. It therefore has a period of six ticks and a 50% duty cycle.
- R5: While the effective clear is high on a tick, the divider is parked: `main_clk`=0 and `periph_clk`=0. The first tick after the effective clear goes low drives `main_clk` high.
- R6: With `SYNC_STAGES`=2 (the default), a level on `clr_in` reaches the divider on the third tick after it is sampled. With `SYNC_STAGES`=0 it acts on the very next tick.
- R7: `reset_out` takes the inverse of `res_n` only on a tick where `main_clk` falls. It holds its value at every other time.
- R8: `osc_out` always equals `xtal_in`, whatever the value of `src_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low initialization |
| xtal_in | input | 1 | Oscillator source clock level |
| ext_in | input | 1 | External frequency source level |
| src_sel | input | 1 | Source strap: 0 oscillator, 1 external |
| clr_in | input | 1 | Active-high phase-alignment clear |
| res_n | input | 1 | Active-low reset request |
| osc_out | output | 1 | Pass-through of the oscillator source |
| main_clk | output | 1 | Divided clock, one-third duty |
| periph_clk | output | 1 | Half-rate peripheral clock, 50% duty |
| reset_out | output | 1 | Retimed active-high reset |

## Verification
The divider is driven first from the oscillator source and then from the external source. The two sources toggle at different rates, so a mix-up in source selection shows up as a wrong output period. A long stretch with only the unselected source toggling separates true edge selection from level sampling. Clear pulses are applied to one instance with the synchronizer and one without. Comparing both instances every cycle against a behavioural model exposes synchronizer latency, the parked state and the release phase. Toggling the reset request at arbitrary points shows that `reset_out` moves only at divided-clock falling edges.

// File: rtl/div3_pkg.sv
// Shared definitions for the divide-by-three clock generator.
// Assumes: every consumer compiles this package first.
package div3_pkg;
    localparam int unsigned DEF_DIV_RATIO   = 3;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_EXT  = 1'b1
    } src_pick_e;
endpackage

// File: rtl/src_edge_pick.sv
// Chooses a source clock level and emits a one-cycle tick on its rising edge.
// Assumes: both source levels are already stable with respect to clk.
module src_edge_pick
    import div3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_in,
    input  logic ext_in,
    input  logic src_sel,
    output logic tick
);
    logic      xtal_q;
    logic      ext_q;
    src_pick_e pick;

    assign pick = src_pick_e'(src_sel);

    // Remember the previous level of each source for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xtal_q <= 1'b0;
            ext_q  <= 1'b0;
        end else begin
            xtal_q <= xtal_in;
            ext_q  <= ext_in;
        end
    end

    // A rising edge on the picked source is one input-clock event.
    always_comb begin
        if (pick == SRC_EXT) tick = ext_in & ~ext_q;
        else                 tick = xtal_in & ~xtal_q;
    end
endmodule

// File: rtl/clr_retimer.sv
// Passes the clear request through STAGES flops advanced by source ticks.
// Assumes: STAGES of 0 means the request is used as is.
module clr_retimer #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr_in,
    output logic clr_eff
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign clr_eff = clr_in;
        end else begin : g_chain
            logic [STAGES-1:0] sh;

            // Shift the request one stage per input-clock event.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh <= '0;
                end else if (tick) begin
                    sh[0] <= clr_in;
                    for (int i = 1; i < int'(STAGES); i++) sh[i] <= sh[i-1];
                end
            end

            assign clr_eff = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/div3_core.sv
// Modulo-DIV_RATIO counter producing the divided and peripheral clocks.
// Assumes: tick is a single-cycle strobe; the clear parks the counter at its last state.
module div3_core #(
    parameter int unsigned DIV_RATIO = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr_eff,
    output logic main_clk,
    output logic periph_clk,
    output logic main_fall
);
    localparam int unsigned CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;

    // Next count: wrap after the last state, park while cleared.
    always_comb begin
        if (clr_eff)          cnt_nx = LAST;
        else if (cnt == LAST) cnt_nx = '0;
        else                  cnt_nx = cnt + 1'b1;
    end

    assign main_fall = tick & main_clk;

    // Advance the counter and register the divided clock glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= LAST;
            main_clk <= 1'b0;
        end else if (tick) begin
            cnt      <= cnt_nx;
            main_clk <= (cnt_nx == '0);
        end
    end

    // Toggle the peripheral clock at each divided-clock falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)            periph_clk <= 1'b0;
        else if (tick && clr_eff) periph_clk <= 1'b0;
        else if (main_fall)    periph_clk <= ~periph_clk;
    end
endmodule

// File: rtl/rstout_retime.sv
// Retimes the active-low reset request onto the divided-clock falling edge.
// Assumes: main_fall marks exactly the cycles where the divided clock drops.
module rstout_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic main_fall,
    input  logic res_n,
    output logic reset_out
);
    // Capture the inverted request only at the falling-edge event.
    always_ff @(posedge clk) begin
        if (!rst_n)         reset_out <= 1'b1;
        else if (main_fall) reset_out <= ~res_n;
    end
endmodule

// File: rtl/phase_div3_clkgen.sv
// Top: source selection, clear retiming, divide-by-DIV_RATIO and reset retiming.
// Assumes: clk samples both sources at least twice per source half-period.
module phase_div3_clkgen
    import div3_pkg::*;
#(
    parameter int unsigned DIV_RATIO   = DEF_DIV_RATIO,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_in,
    input  logic ext_in,
    input  logic src_sel,
    input  logic clr_in,
    input  logic res_n,
    output logic osc_out,
    output logic main_clk,
    output logic periph_clk,
    output logic reset_out
);
    logic src_tick;
    logic clr_eff;
    logic main_fall;

    assign osc_out = xtal_in;

    src_edge_pick u_pick (
        .clk(clk), .rst_n(rst_n), .xtal_in(xtal_in), .ext_in(ext_in),
        .src_sel(src_sel), .tick(src_tick)
    );

    clr_retimer #(.STAGES(SYNC_STAGES)) u_clr (
        .clk(clk), .rst_n(rst_n), .tick(src_tick), .clr_in(clr_in), .clr_eff(clr_eff)
    );

    div3_core #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(src_tick), .clr_eff(clr_eff),
        .main_clk(main_clk), .periph_clk(periph_clk), .main_fall(main_fall)
    );

    rstout_retime u_rst (
        .clk(clk), .rst_n(rst_n), .main_fall(main_fall), .res_n(res_n),
        .reset_out(reset_out)
    );
endmodule

// File: rtl/phase_div3_clkgen_chk.sv
// Temporal properties of the clock generator, bound to its top.
// Assumes: tick and clr_eff are the top's internal strobe and effective clear.
module phase_div3_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic clr_eff,
    input logic main_clk,
    input logic periph_clk,
    input logic reset_out
);
    // R1: reset parks the outputs
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!main_clk && !periph_clk && reset_out));

    // R2: divided clock only moves on ticks
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(main_clk));

    // R2: high for a single tick
    a_r2_single_tick_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && main_clk) |=> !main_clk);

    // R4: peripheral clock only moves at a falling edge or a clear
    a_r4_periph_edges: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && (main_clk || clr_eff)) |=> $stable(periph_clk));

    // R5: clear parks both clocks low
    a_r5_clear_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clr_eff) |=> (!main_clk && !periph_clk));

    // R7: retimed reset only moves at a falling edge
    a_r7_reset_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && main_clk) |=> $stable(reset_out));
endmodule

bind phase_div3_clkgen phase_div3_clkgen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(src_tick), .clr_eff(clr_eff),
    .main_clk(main_clk), .periph_clk(periph_clk), .reset_out(reset_out)
);

// File: tb/phase_div3_clkgen_test.sv
// Behavioural reference for one generator instance.
module div3_ref_model #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_in,
    input  logic ext_in,
    input  logic src_sel,
    input  logic clr_in,
    input  logic res_n,
    output logic e_main,
    output logic e_periph,
    output logic e_rst
);
    int phase;
    bit px, pe, pc, ro;
    bit pipe[$];

    assign e_main   = (phase == 0);
    assign e_periph = pc;
    assign e_rst    = ro;

    always @(posedge clk) begin
        bit t, c, fall;
        if (!rst_n) begin
            phase = 2; pc = 0; ro = 1; px = 0; pe = 0;
            pipe.delete();
            for (int i = 0; i < STAGES; i++) pipe.push_back(1'b0);
        end else begin
            t = src_sel ? (ext_in && !pe) : (xtal_in && !px);
            px = xtal_in; pe = ext_in;
            if (t) begin
                if (STAGES == 0) c = clr_in;
                else begin
                    c = pipe.pop_front();
                    pipe.push_back(clr_in);
                end
                fall = (phase == 0);
                if (fall) ro = !res_n;
                if (c) begin
                    phase = 2; pc = 0;
                end else begin
                    if (fall) pc = !pc;
                    phase = (phase + 1) % 3;
                end
            end
        end
    end
endmodule

module phase_div3_clkgen_test;
    logic clk = 0;
    logic rst_n = 0;
    logic xtal_in = 0, ext_in = 0, src_sel = 0, clr_in = 0, res_n = 1;
    logic osc_out, main_clk, periph_clk, reset_out;
    logic osc0, main0, periph0, rst0;
    logic em, ep, er, em0, ep0, er0;
    int checks = 0, errors = 0, cyc = 0;
    bit xen = 0, een = 0, done = 0;

    always #5 clk = ~clk;

    phase_div3_clkgen uut (
        .clk(clk), .rst_n(rst_n), .xtal_in(xtal_in), .ext_in(ext_in),
        .src_sel(src_sel), .clr_in(clr_in), .res_n(res_n), .osc_out(osc_out),
        .main_clk(main_clk), .periph_clk(periph_clk), .reset_out(reset_out)
    );

    phase_div3_clkgen #(.SYNC_STAGES(0)) uut_nosync (
        .clk(clk), .rst_n(rst_n), .xtal_in(xtal_in), .ext_in(ext_in),
        .src_sel(src_sel), .clr_in(clr_in), .res_n(res_n), .osc_out(osc0),
        .main_clk(main0), .periph_clk(periph0), .reset_out(rst0)
    );

    div3_ref_model #(.STAGES(2)) m_sync (
        .clk(clk), .rst_n(rst_n), .xtal_in(xtal_in), .ext_in(ext_in),
        .src_sel(src_sel), .clr_in(clr_in), .res_n(res_n),
        .e_main(em), .e_periph(ep), .e_rst(er)
    );

    div3_ref_model #(.STAGES(0)) m_nosync (
        .clk(clk), .rst_n(rst_n), .xtal_in(xtal_in), .ext_in(ext_in),
        .src_sel(src_sel), .clr_in(clr_in), .res_n(res_n),
        .e_main(em0), .e_periph(ep0), .e_rst(er0)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison against the models, sampled after the edge settles.
    always @(posedge clk) begin
        #2;
        if (!done) begin
            check(main_clk === em, "R2/R5/R6 main_clk", main_clk, em);
            check(periph_clk === ep, "R4 periph_clk", periph_clk, ep);
            check(reset_out === er, "R7 reset_out", reset_out, er);
            check(main0 === em0, "R6 nosync main_clk", main0, em0);
            check(periph0 === ep0, "R5 nosync periph_clk", periph0, ep0);
            check(rst0 === er0, "R7 nosync reset_out", rst0, er0);
            check(osc_out === xtal_in, "R8 osc_out", osc_out, xtal_in);
        end
    end

    task automatic run(input int n);
        repeat (n) begin
            @(negedge clk);
            cyc++;
            if (xen && (cyc % 2 == 0)) xtal_in = ~xtal_in;
            if (een && (cyc % 3 == 0)) ext_in = ~ext_in;
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #500us;
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run completion)");
        finish_up();
    end

    initial begin
        int m, p;
        xen = 1; een = 1;
        run(3);
        @(posedge clk); #2;
        check(main_clk == 0 && periph_clk == 0, "R1 clocks in reset", {main_clk, periph_clk}, 0);
        check(reset_out == 1, "R1 reset_out in reset", reset_out, 1);
        @(negedge clk); rst_n = 1;
        src_sel = 0; run(80);
        src_sel = 1; run(80);
        // R3: only the unselected source toggles
        een = 0; run(4);
        m = main_clk; p = periph_clk;
        run(40);
        check(main_clk == m, "R3 main_clk unchanged by unselected source", main_clk, m);
        check(periph_clk == p, "R3 periph_clk unchanged by unselected source", periph_clk, p);
        een = 1;
        // R5/R6: hold the clear long enough to park both instances
        clr_in = 1; run(40);
        check(main_clk == 0 && periph_clk == 0, "R5 parked with sync", {main_clk, periph_clk}, 0);
        check(main0 == 0 && periph0 == 0, "R5 parked without sync", {main0, periph0}, 0);
        clr_in = 0; run(60);
        src_sel = 0;
        clr_in = 1; run(9); clr_in = 0; run(50);
        // R7: reset request moves reset_out only at falling edges
        res_n = 0; run(40);
        check(reset_out == 1, "R7 reset_out asserted", reset_out, 1);
        res_n = 1; run(40);
        check(reset_out == 0, "R7 reset_out released", reset_out, 0);
        res_n = 0; run(5); res_n = 1; run(30);
        src_sel = 1; clr_in = 1; run(7); clr_in = 0; run(60);
        @(posedge clk); #3;
        finish_up();
    end
endmodule